// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This sequencer carries out the port transfer instructions of an 8-bit processor core. The core hands it an already fetched opcode pair with a one-cycle `start` pulse, together with the accumulator, the 16-bit memory pointer, the 8-bit byte counter, the 8-bit port register and the flag byte. The sequencer then steps through the machine cycles of the instruction one T-state per clock. It issues memory and I/O bus cycles on a request/acknowledge bus and returns the updated pointer, counter and flags.

Four forms are recognised. The first is the direct output form, 0xD3 followed by a port number. The second is the single decrementing output, 0xED 0xAB. The third and fourth are the repeating input and repeating output forms, 0xED 0xB2 and 0xED 0xB3. The repeating forms decrement the counter before testing it, so a start value of zero moves 256 bytes. Between passes of a repeating form, a pending interrupt request stops the block early. The pointer and counter keep their updated values, so the core can re-issue the same opcode later to resume.

The bus protocol is simple. A request stays high with a stable address and write data until the bus answers with a one-cycle acknowledge. A late acknowledge stretches the current machine cycle.

Top module: `blkio_seq`

## Requirements
- R1: After reset, `busy`, `done`, `irq_taken` and `bus_req` are low, and `hl_out`, `b_out` and `f_out` are zero.
- R2: Opcode 0xD3 with port byte n performs one I/O write of the accumulator to address {accumulator, n}. `busy` stays high for 11 cycles, and `f_out` equals `f_in` unchanged.
- R3: Opcode 0xED 0xAB performs a memory read at the pointer, then an I/O write of that byte to address {counter, port}. It then decrements the pointer and the counter. `busy` stays high for 16 cycles.
- R4: After any 0xED form, flag bit 6 (Z) is 1 exactly when the decremented counter is zero and flag bit 1 (N) is 1. All other flag bits keep their `f_in` values.
- R5: Opcode 0xED 0xB2 performs, on each pass, an I/O read from {counter, port} and then a memory write of that byte at the pointer. It then increments the pointer and decrements the counter.
- R6: Opcode 0xED 0xB3 performs, on each pass, a memory read at the pointer and then an I/O write of that byte to {counter, port}. It then increments the pointer and decrements the counter.
- R7: A repeating form ends only when the decremented counter is zero. A start count of 0 gives 256 passes, and the block ends with the counter at 0.
- R8: With immediate acknowledges, each pass of a repeating form that is not the last takes 21 cycles and the last pass takes 16 cycles of `busy`.
- R9: If `irq` is high at the end of a non-final pass, the block stops with a one-cycle `irq_taken` pulse and no `done`. The pointer and counter hold the values after that pass, and re-issuing the opcode with them completes the remaining passes.
- R10: The pointer wraps modulo 2^16 in both directions.
- R11: A `start` with any other opcode is ignored: no `busy`, no bus cycle, no change of `hl_out`.
- R12: `bus_req` stays high with stable `bus_addr` and `bus_wdata` until `bus_ack`. Each clock of acknowledge delay beyond the T-states of the machine cycle adds one cycle of `busy`.
- R13: `done` is a single-cycle pulse that follows the last cycle of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction when idle |
| op_pre | input | 8 | First opcode byte |
| op_sub | input | 8 | Second opcode byte, or port number for 0xD3 |
| acc_in | input | 8 | Accumulator value |
| hl_in | input | 16 | Memory pointer start value |
| b_in | input | 8 | Byte counter start value |
| c_in | input | 8 | Port register |
| f_in | input | 8 | Flag byte on entry |
| irq | input | 1 | Interrupt request, sampled between passes |
| bus_req | output | 1 | Bus cycle request |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_io | output | 1 | 1 I/O space, 0 memory space |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Bus cycle complete |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction finished, one cycle |
| irq_taken | output | 1 | Block stopped for an interrupt, one cycle |
| hl_out | output | 16 | Current memory pointer |
| b_out | output | 8 | Current byte counter |
| f_out | output | 8 | Current flag byte |

## Verification
The hardest situation to reach is the interrupt exit in the middle of a block. It exists only in the five-state window after a non-final pass, and the resumed run has to continue from the stopped state. The bench holds `irq` high from the start of a three-pass output block, so the window of the first pass catches it. It then checks the pulse, the counter and the pointer. Finally it re-issues the opcode with the returned values and `irq` low, and checks that the remaining two passes and the cycle total come out right. The 256-pass case and the stretched bus cycles are reached with a zero start count and a delayed acknowledge.

// File: rtl/blkio_seq.sv
module blkio_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  op_pre,
  input  logic [7:0]  op_sub,
  input  logic [7:0]  acc_in,
  input  logic [15:0] hl_in,
  input  logic [7:0]  b_in,
  input  logic [7:0]  c_in,
  input  logic [7:0]  f_in,
  input  logic        irq,
  output logic        bus_req,
  output logic        bus_wr,
  output logic        bus_io,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  input  logic        bus_ack,
  output logic        busy,
  output logic        done,
  output logic        irq_taken,
  output logic [15:0] hl_out,
  output logic [7:0]  b_out,
  output logic [7:0]  f_out
);

  localparam logic [7:0] OP_DIR  = 8'hD3;
  localparam logic [7:0] OP_ED   = 8'hED;
  localparam logic [7:0] OP_OUTD = 8'hAB;
  localparam logic [7:0] OP_INIR = 8'hB2;
  localparam logic [7:0] OP_OTIR = 8'hB3;
  localparam int unsigned ZBIT = 6;
  localparam int unsigned NBIT = 1;

  typedef enum logic [2:0] {S_IDLE, S_F1, S_F2, S_X1, S_X2, S_RW} st_t;
  typedef enum logic [1:0] {M_DIR, M_OUTD, M_INIR, M_OTIR} md_t;

  st_t         st;
  md_t         md;
  logic [2:0]  tcnt;
  logic [2:0]  len;
  logic        got;
  logic [7:0]  acc, port_n, dbuf, b, c, f;
  logic [15:0] hl;

  wire dec_dir  = op_pre == OP_DIR;
  wire dec_ed   = op_pre == OP_ED &&
                  (op_sub == OP_OUTD || op_sub == OP_INIR || op_sub == OP_OTIR);
  wire accept   = start && st == S_IDLE && (dec_dir || dec_ed);
  wire bus_mc   = st == S_X1 || st == S_X2;
  wire rep_md   = md == M_INIR || md == M_OTIR;
  wire last_t   = tcnt == len - 3'd1 && (!bus_mc || got);
  wire [7:0]  b_dec   = b - 8'd1;
  wire [15:0] hl_next = (md == M_OUTD) ? hl - 16'd1 : hl + 16'd1;
  wire [15:0] io_addr = (md == M_DIR) ? {acc, port_n} : {b, c};

  always_comb begin
    case (st)
      S_F1:    len = 3'd4;
      S_F2:    len = (md == M_DIR) ? 3'd3 : 3'd5;
      S_X1:    len = 3'd3;
      S_X2:    len = 3'd4;
      S_RW:    len = 3'd5;
      default: len = 3'd1;
    endcase
  end

  assign bus_req   = bus_mc && !got;
  assign bus_wr    = st == S_X2;
  assign bus_io    = bus_mc && ((st == S_X1) ? (md == M_INIR) : (md != M_INIR));
  assign bus_addr  = !bus_mc ? 16'h0000 : (bus_io ? io_addr : hl);
  assign bus_wdata = (st != S_X2) ? 8'h00 : ((md == M_DIR) ? acc : dbuf);

  assign busy   = st != S_IDLE;
  assign hl_out = hl;
  assign b_out  = b;
  assign f_out  = f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      md        <= M_DIR;
      tcnt      <= 3'd0;
      got       <= 1'b0;
      acc       <= 8'h00;
      port_n    <= 8'h00;
      dbuf      <= 8'h00;
      b         <= 8'h00;
      c         <= 8'h00;
      f         <= 8'h00;
      hl        <= 16'h0000;
      done      <= 1'b0;
      irq_taken <= 1'b0;
    end else begin
      done      <= 1'b0;
      irq_taken <= 1'b0;
      if (bus_req && bus_ack) begin
        got <= 1'b1;
        if (st == S_X1) dbuf <= bus_rdata;
      end
      case (st)
        S_IDLE: begin
          if (accept) begin
            st     <= S_F1;
            tcnt   <= 3'd0;
            got    <= 1'b0;
            acc    <= acc_in;
            port_n <= op_sub;
            hl     <= hl_in;
            b      <= b_in;
            c      <= c_in;
            f      <= f_in;
            if (dec_dir)                md <= M_DIR;
            else if (op_sub == OP_OUTD) md <= M_OUTD;
            else if (op_sub == OP_INIR) md <= M_INIR;
            else                        md <= M_OTIR;
          end
        end
        default: begin
          if (!last_t) begin
            if (tcnt != len - 3'd1) tcnt <= tcnt + 3'd1;
          end else begin
            tcnt <= 3'd0;
            got  <= 1'b0;
            case (st)
              S_F1: st <= S_F2;
              S_F2: st <= (md == M_DIR) ? S_X2 : S_X1;
              S_X1: st <= S_X2;
              S_X2: begin
                if (md != M_DIR) begin
                  hl      <= hl_next;
                  b       <= b_dec;
                  f[ZBIT] <= b_dec == 8'h00;
                  f[NBIT] <= 1'b1;
                end
                if (rep_md && b_dec != 8'h00) begin
                  st <= S_RW;
                end else begin
                  st   <= S_IDLE;
                  done <= 1'b1;
                end
              end
              S_RW: begin
                if (irq) begin
                  st        <= S_IDLE;
                  irq_taken <= 1'b1;
                end else begin
                  st <= S_F1;
                end
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/blkio_seq_chk.sv
module blkio_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        bus_req,
  input logic        bus_ack,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        done,
  input logic        irq_taken,
  input logic [15:0] hl_out,
  input logic [7:0]  b_out,
  input logic [7:0]  f_out,
  input logic [1:0]  md
);

  a_r1_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata));

  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_taken_mid_block: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> !done && !busy && b_out != 8'h00);

  a_r7_repeat_ends_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && md[1] |-> b_out == 8'h00 && f_out[6] && f_out[1]);

  a_r10_ptr_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && hl_out != $past(hl_out) |->
      (hl_out == $past(hl_out) + 16'd1) || (hl_out == $past(hl_out) - 16'd1));

endmodule

bind blkio_seq blkio_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .done      (done),
  .irq_taken (irq_taken),
  .hl_out    (hl_out),
  .b_out     (b_out),
  .f_out     (f_out),
  .md        (md)
);

// File: tb/blkio_seq_tb.sv
module blkio_seq_tb;

  localparam int LOGN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_pre = 8'h00, op_sub = 8'h00, acc_in = 8'h00;
  logic [15:0] hl_in = 16'h0000;
  logic [7:0]  b_in = 8'h00, c_in = 8'h00, f_in = 8'h00;
  logic        irq = 1'b0;
  logic        bus_req, bus_wr, bus_io;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = 8'h00;
  logic        bus_ack = 1'b0;
  logic        busy, done, irq_taken;
  logic [15:0] hl_out;
  logic [7:0]  b_out, f_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wait_n = 0;
  int wc = 0;
  int nlog = 0;
  bit saw_done, saw_taken;
  logic [7:0]  mem [256];
  logic        lg_io [LOGN];
  logic        lg_wr [LOGN];
  logic [15:0] lg_addr [LOGN];
  logic [7:0]  lg_dat [LOGN];

  always #10 clk = ~clk;

  blkio_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_pre(op_pre), .op_sub(op_sub),
    .acc_in(acc_in), .hl_in(hl_in), .b_in(b_in), .c_in(c_in), .f_in(f_in),
    .irq(irq), .bus_req(bus_req), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .busy(busy), .done(done), .irq_taken(irq_taken),
    .hl_out(hl_out), .b_out(b_out), .f_out(f_out)
  );

  function automatic logic [7:0] io_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (busy) cyc++;
    if (bus_req && !bus_ack) begin
      if (wc >= wait_n) begin
        wc = 0;
        bus_ack = 1'b1;
        if (nlog < LOGN) begin
          lg_io[nlog]   = bus_io;
          lg_wr[nlog]   = bus_wr;
          lg_addr[nlog] = bus_addr;
        end
        if (bus_wr) begin
          if (nlog < LOGN) lg_dat[nlog] = bus_wdata;
          if (!bus_io) mem[bus_addr[7:0]] = bus_wdata;
        end else begin
          bus_rdata = bus_io ? io_val(bus_addr) : mem[bus_addr[7:0]];
          if (nlog < LOGN) lg_dat[nlog] = bus_rdata;
        end
        nlog++;
      end else begin
        wc++;
      end
    end else begin
      bus_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] p, input logic [7:0] s, input logic [7:0] a,
                        input logic [15:0] h, input logic [7:0] bb,
                        input logic [7:0] cc, input logic [7:0] ff);
    @(negedge clk);
    op_pre = p; op_sub = s; acc_in = a; hl_in = h; b_in = bb; c_in = cc; f_in = ff;
    cyc = 0; nlog = 0; saw_done = 0; saw_taken = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done || irq_taken) break;
      @(negedge clk);
    end
    saw_done = done;
    saw_taken = irq_taken;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !irq_taken && !bus_req, "R1 idle outputs", {busy, done, irq_taken, bus_req}, 0);
    chk(hl_out == 16'h0 && b_out == 8'h0 && f_out == 8'h0, "R1 regs", {hl_out, b_out, f_out}, 0);
  endtask

  task automatic t_direct;
    run_op(8'hD3, 8'h34, 8'h9C, 16'h1200, 8'h07, 8'h11, 8'hA5);
    chk(saw_done, "R2 done", saw_done, 1);
    chk(cyc == 11, "R2 cycles", cyc, 11);
    chk(nlog == 1 && lg_io[0] && lg_wr[0], "R2 one io write", nlog, 1);
    chk(lg_addr[0] == 16'h9C34 && lg_dat[0] == 8'h9C, "R2 addr/data", {lg_addr[0], lg_dat[0]}, 24'h9C349C);
    chk(f_out == 8'hA5 && b_out == 8'h07 && hl_out == 16'h1200, "R2 flags/regs kept", f_out, 8'hA5);
    @(negedge clk);
    chk(!done, "R13 done one cycle", done, 0);
  endtask

  task automatic t_outd;
    run_op(8'hED, 8'hAB, 8'h00, 16'h0042, 8'h05, 8'h77, 8'h41);
    chk(cyc == 16, "R3 cycles", cyc, 16);
    chk(nlog == 2 && !lg_io[0] && !lg_wr[0] && lg_addr[0] == 16'h0042, "R3 mem read", lg_addr[0], 16'h0042);
    chk(lg_io[1] && lg_wr[1] && lg_addr[1] == 16'h0577 && lg_dat[1] == mem[8'h42], "R3 io write", {lg_addr[1], lg_dat[1]}, {16'h0577, mem[8'h42]});
    chk(hl_out == 16'h0041 && b_out == 8'h04, "R3 decrement", {hl_out, b_out}, 24'h004104);
    chk(f_out == 8'h03, "R4 Z clear N set", f_out, 8'h03);
    run_op(8'hED, 8'hAB, 8'h00, 16'h0000, 8'h01, 8'h10, 8'h81);
    chk(hl_out == 16'hFFFF && b_out == 8'h00, "R10 down wrap", hl_out, 16'hFFFF);
    chk(f_out == 8'hC3, "R4 Z set", f_out, 8'hC3);
  endtask

  task automatic t_block(input bit inp, input logic [7:0] b0, input logic [15:0] h0);
    int passes;
    int bad;
    passes = (b0 == 0) ? 256 : int'(b0);
    run_op(8'hED, inp ? 8'hB2 : 8'hB3, 8'h00, h0, b0, 8'h40, 8'h81);
    chk(saw_done, "R7 done", saw_done, 1);
    chk(cyc == (passes - 1) * 21 + 16, "R8 cycles", cyc, (passes - 1) * 21 + 16);
    chk(nlog == 2 * passes, "R7 transfer count", nlog, 2 * passes);
    chk(hl_out == h0 + 16'(passes) && b_out == 8'h00, "R10 pointer final", hl_out, h0 + 16'(passes));
    chk(f_out == 8'hC3, "R4 block flags", f_out, 8'hC3);
    bad = 0;
    for (int i = 0; i < passes && 2 * i + 1 < LOGN; i++) begin
      logic [15:0] ia, ma;
      ia = {8'(b0 - 8'(i)), 8'h40};
      ma = h0 + 16'(i);
      if (inp) begin
        if (!(lg_io[2*i] && !lg_wr[2*i] && lg_addr[2*i] == ia)) bad++;
        if (!(!lg_io[2*i+1] && lg_wr[2*i+1] && lg_addr[2*i+1] == ma && lg_dat[2*i+1] == io_val(ia))) bad++;
      end else begin
        if (!(!lg_io[2*i] && !lg_wr[2*i] && lg_addr[2*i] == ma)) bad++;
        if (!(lg_io[2*i+1] && lg_wr[2*i+1] && lg_addr[2*i+1] == ia && lg_dat[2*i+1] == lg_dat[2*i])) bad++;
      end
    end
    chk(bad == 0, inp ? "R5 pass sequence" : "R6 pass sequence", bad, 0);
  endtask

  task automatic t_irq;
    logic [15:0] h;
    logic [7:0] bb;
    irq = 1'b1;
    run_op(8'hED, 8'hB3, 8'h00, 16'h0010, 8'h03, 8'h22, 8'h01);
    irq = 1'b0;
    chk(saw_taken && !saw_done, "R9 taken no done", {saw_taken, saw_done}, 2'b10);
    chk(cyc == 21 && nlog == 2, "R9 one pass", cyc, 21);
    chk(b_out == 8'h02 && hl_out == 16'h0011, "R9 regs held", {hl_out, b_out}, 24'h001102);
    @(negedge clk);
    chk(!irq_taken, "R9 pulse", irq_taken, 0);
    h = hl_out; bb = b_out;
    run_op(8'hED, 8'hB3, 8'h00, h, bb, 8'h22, f_out);
    chk(saw_done && cyc == 37 && nlog == 4, "R9 resume", cyc, 37);
    chk(lg_addr[3] == 16'h0122 && hl_out == 16'h0013 && b_out == 8'h00, "R9 resume end", hl_out, 16'h0013);
  endtask

  task automatic t_bad_op;
    logic [15:0] h;
    h = hl_out;
    run_op(8'hED, 8'h00, 8'h00, 16'hBEEF, 8'h09, 8'h00, 8'h00);
    chk(cyc == 0 && nlog == 0 && !saw_done, "R11 no activity", cyc, 0);
    chk(hl_out == h, "R11 pointer kept", hl_out, h);
  endtask

  task automatic t_wait;
    wait_n = 3;
    run_op(8'hED, 8'hAB, 8'h00, 16'h0030, 8'h02, 8'h05, 8'h00);
    wait_n = 0;
    chk(cyc == 19, "R12 stretched cycles", cyc, 19);
    chk(nlog == 2 && b_out == 8'h01 && hl_out == 16'h002F, "R12 result", {hl_out, b_out}, 24'h002F01);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_outd();
    t_block(1'b0, 8'h01, 16'h0020);
    t_block(1'b0, 8'h03, 16'hFFFF);
    t_block(1'b1, 8'h03, 16'h0080);
    t_block(1'b1, 8'h00, 16'h0100);
    t_block(1'b0, 8'h00, 16'h0200);
    t_irq();
    t_bad_op();
    t_wait();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule